// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Lookup

This block is the lookup pipeline of a level-one data cache whose set index is drawn only from address bits inside the page offset. The page offset is identical in the virtual and the physical address. So the block can read the tags and data of every way in the indexed set in the same cycle that it searches a small set-associative translation buffer (TLB) with the virtual page number. In the following cycle it builds the physical tag from the translated page number and compares it with every way. It then reports hit or miss, the matching way, the addressed data word and the physical address, and it moves the set's pseudo-LRU state on a hit.

When the virtual page number is not in the TLB, the block throws away the set it fetched and raises a translation request that names the missing page. It then waits for a fill on the fill port. Once the fill is written, it re-runs the stalled access from the start. Requests use a valid/ready handshake, and a request is taken on a clock edge where both are high. `req_ready` depends only on internal state, never on `req_valid`. It is low while a translation is outstanding, during the replay cycle, and while the access in the read stage has missed the TLB. Responses carry no back-pressure: `rsp_valid` is high for one cycle per access, and the consumer must take the response in that cycle. A simple install port writes lines into the arrays, since line refill is handled elsewhere. All addresses are 32-bit word addresses: byte address bits [1:0] are dropped.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset `req_ready`=1, `rsp_valid`=0, `tlbmiss_req`=0, and every TLB entry is invalid, so the first access to any page raises a translation request.
- R2: An accepted request whose page is in the TLB and whose indexed set holds a valid line with an equal physical tag gives, two rising edges after acceptance, `rsp_valid`=1, `rsp_hit`=1, `rsp_way` set to that way, and `rsp_data` set to the word selected by address bits [5:2]. At most one way matches.
- R3: When the TLB hits but no valid way matches, the response has `rsp_hit`=0 and `rsp_data`=0. On every response, `rsp_paddr` is the translated page number followed by address bits [11:2].
- R4: The set is picked by byte address bits [8:6], which lie inside the page offset. The physical tag is physical address bits [31:9]. Two virtual pages translated to the same physical page therefore hit the same line in the same way.
- R5: On a TLB miss no response is produced. `tlbmiss_req` stays high with `tlbmiss_vpn` (byte address bits [31:12]) held stable until a fill arrives, and `req_ready` is 0 during that time.
- R6: The cycle after a fill arrives while `tlbmiss_req` is high, the missed access is re-run. It produces exactly one response, with the outcome that the new translation gives.
- R7: The TLB has 16 sets of 4 ways. Its set is picked by VPN bits [3:0]. Each set refills its ways in round-robin order, starting from way 0 after reset, so the fifth fill into a set displaces the first.
- R8: Each cache set keeps a 7-node tree pseudo-LRU. In each node, 0 points to the lower-numbered half. A hit sets every node on its path to point away from the hit way. A miss response reports, in `rsp_victim`, the way found by following the pointers from the root. In a fresh set, hitting way 0 makes the victim 4, and then hitting way 4 makes it 2. After hits to ways 0 through 7 in order, the victim is 0.
- R9: Requests that hit the TLB are accepted on consecutive cycles, and their responses appear on consecutive cycles in request order.
- R10: A request that arrives behind an access that missed the TLB is accepted only after the replay has been issued. Its response follows the replayed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 30 | Virtual word address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Line present |
| rsp_way | output | 3 | Matching way (0 on miss) |
| rsp_data | output | 32 | Addressed word (0 on miss) |
| rsp_paddr | output | 30 | Translated physical word address |
| rsp_victim | output | 3 | Pseudo-LRU victim of the set |
| inst_valid | input | 1 | Write one word and mark its line valid |
| inst_way | input | 3 | Way to write |
| inst_waddr | input | 30 | Physical word address to install |
| inst_data | input | 32 | Word to install |
| fill_valid | input | 1 | TLB fill strobe |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| tlbmiss_req | output | 1 | Translation request outstanding |
| tlbmiss_vpn | output | 20 | Page that missed |

## Verification
The hardest situation to reach is a younger request queued behind an access that missed the TLB, in the same cycle the miss is detected. The bench issues the missing access and the next request back to back from one thread, while a second thread waits for the translation request and answers it. The scoreboard then requires the replayed response first. Pseudo-LRU state is only visible on miss responses. So the bench places eight distinct physical lines into one set by varying the page-offset bits above the index, and probes that set with a second page between hits.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_REPLAY = 2'd2
  } lk_state_e;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SETS  = 16,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [VPN_W-1:0] rd_vpn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int PTR_W = $clog2(WAYS);

  logic             vld_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [PTR_W-1:0] rr_q  [SETS];

  logic [WAYS-1:0]             rd_vld_q;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag_q;
  logic [WAYS-1:0][PPN_W-1:0]  rd_ppn_q;
  logic [TAG_W-1:0]            cmp_tag_q;

  wire [IDX_W-1:0] fset = fill_vpn[IDX_W-1:0];
  wire [IDX_W-1:0] rset = rd_vpn[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
      end
    end else if (fill_en) begin
      vld_q[fset][rr_q[fset]] <= 1'b1;
      rr_q[fset]              <= rr_q[fset] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fset][rr_q[fset]] <= fill_vpn[VPN_W-1:IDX_W];
      ppn_q[fset][rr_q[fset]] <= fill_ppn;
    end
    if (rd_en) begin
      cmp_tag_q <= rd_vpn[VPN_W-1:IDX_W];
      for (int w = 0; w < WAYS; w++) begin
        rd_vld_q[w] <= vld_q[rset][w];
        rd_tag_q[w] <= tag_q[rset][w];
        rd_ppn_q[w] <= ppn_q[rset][w];
      end
    end
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_vld_q[w] && rd_tag_q[w] == cmp_tag_q) begin
        lk_hit = 1'b1;
        lk_ppn = lk_ppn | rd_ppn_q[w];
      end
    end
  end
endmodule

// File: rtl/vipt_tagdata.sv
module vipt_tagdata #(
  parameter int SETS   = 8,
  parameter int WAYS   = 8,
  parameter int WORDS  = 16,
  parameter int TAG_W  = 23,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic [$clog2(SETS)-1:0]         rd_set,
  input  logic [$clog2(WORDS)-1:0]        rd_word,
  input  logic                            wr_en,
  input  logic [$clog2(SETS)-1:0]         wr_set,
  input  logic [$clog2(WAYS)-1:0]         wr_way,
  input  logic [$clog2(WORDS)-1:0]        wr_word,
  input  logic [TAG_W-1:0]                wr_tag,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [WAYS-1:0]                 rd_vld,
  output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
  output logic [WAYS-1:0][DATA_W-1:0]     rd_data
);
  logic              vld_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS][WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]           <= wr_tag;
      data_q[wr_set][wr_way][wr_word] <= wr_data;
    end
    if (rd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        rd_vld[w]  <= vld_q[rd_set][w];
        rd_tag[w]  <= tag_q[rd_set][w];
        rd_data[w] <= data_q[rd_set][w][rd_word];
      end
    end
  end
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
  parameter int SETS = 8,
  parameter int WAYS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic [$clog2(SETS)-1:0] set_sel,
  input  logic [$clog2(WAYS)-1:0] upd_way,
  output logic [$clog2(WAYS)-1:0] victim
);
  localparam int LVL = $clog2(WAYS);

  logic [WAYS-1:1] st_q [SETS];
  logic [WAYS-1:1] st_nxt;

  always_comb begin
    int unsigned node;
    st_nxt = st_q[set_sel];
    node   = 1;
    for (int l = 0; l < LVL; l++) begin
      st_nxt[node] = ~upd_way[LVL-1-l];
      node         = node * 2 + 32'(upd_way[LVL-1-l]);
    end
  end

  always_comb begin
    int unsigned node;
    node = 1;
    for (int l = 0; l < LVL; l++) node = node * 2 + 32'(st_q[set_sel][node]);
    victim = LVL'(node - WAYS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else if (upd_en) begin
      st_q[set_sel] <= st_nxt;
    end
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup #(
  parameter int VA_W      = 32,
  parameter int PPN_W     = 20,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int SETS      = 8,
  parameter int WAYS      = 8,
  parameter int TLB_SETS  = 16,
  parameter int TLB_WAYS  = 4,
  parameter int DATA_W    = 32
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              req_valid,
  output logic                                              req_ready,
  input  logic [VA_W-$clog2(DATA_W/8)-1:0]                  req_vaddr,
  output logic                                              rsp_valid,
  output logic                                              rsp_hit,
  output logic [$clog2(WAYS)-1:0]                           rsp_way,
  output logic [DATA_W-1:0]                                 rsp_data,
  output logic [PPN_W+PAGE_BITS-$clog2(DATA_W/8)-1:0]       rsp_paddr,
  output logic [$clog2(WAYS)-1:0]                           rsp_victim,
  input  logic                                              inst_valid,
  input  logic [$clog2(WAYS)-1:0]                           inst_way,
  input  logic [PPN_W+PAGE_BITS-$clog2(DATA_W/8)-1:0]       inst_waddr,
  input  logic [DATA_W-1:0]                                 inst_data,
  input  logic                                              fill_valid,
  input  logic [VA_W-PAGE_BITS-1:0]                         fill_vpn,
  input  logic [PPN_W-1:0]                                  fill_ppn,
  output logic                                              tlbmiss_req,
  output logic [VA_W-PAGE_BITS-1:0]                         tlbmiss_vpn
);
  import vipt_pkg::*;

  localparam int WB     = $clog2(DATA_W/8);
  localparam int WA_W   = VA_W - WB;
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int PGW    = PAGE_BITS - WB;
  localparam int LW     = LINE_BITS - WB;
  localparam int WORDS  = 1 << LW;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int PWA_W  = PPN_W + PGW;
  localparam int PTAG_W = PWA_W - LW - IDX_W;

  lk_state_e        st_q;
  logic [WA_W-1:0]  saved_va_q, s1_va_q, rd_va;
  logic             s1_valid_q, rd_en, acc, s1_tlbmiss;

  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;
  logic [WAYS-1:0]              cd_vld, way_hit;
  logic [WAYS-1:0][PTAG_W-1:0]  cd_tag;
  logic [WAYS-1:0][DATA_W-1:0]  cd_data;
  logic [PWA_W-1:0]  s1_pa;
  logic [PTAG_W-1:0] s1_ptag;
  logic              any_hit;
  logic [WAY_W-1:0]  hit_way, victim;
  logic [DATA_W-1:0] hit_data;

  assign acc        = req_valid && req_ready;
  assign s1_tlbmiss = s1_valid_q && !tlb_hit;
  assign req_ready  = (st_q == ST_IDLE) && !s1_tlbmiss;
  assign rd_en      = acc || (st_q == ST_REPLAY);
  assign rd_va      = (st_q == ST_REPLAY) ? saved_va_q : req_vaddr;

  vipt_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(TLB_SETS), .WAYS(TLB_WAYS)) i_tlb (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_vpn(rd_va[WA_W-1 -: VPN_W]),
    .fill_en(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .lk_hit(tlb_hit), .lk_ppn(tlb_ppn));

  vipt_tagdata #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .TAG_W(PTAG_W), .DATA_W(DATA_W)) i_arr (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
    .rd_set(rd_va[LW +: IDX_W]), .rd_word(rd_va[LW-1:0]),
    .wr_en(inst_valid), .wr_set(inst_waddr[LW +: IDX_W]), .wr_way(inst_way),
    .wr_word(inst_waddr[LW-1:0]), .wr_tag(inst_waddr[PWA_W-1 -: PTAG_W]), .wr_data(inst_data),
    .rd_vld(cd_vld), .rd_tag(cd_tag), .rd_data(cd_data));

  // stage 2: physical tag compare against every fetched way
  assign s1_pa   = {tlb_ppn, s1_va_q[PGW-1:0]};
  assign s1_ptag = s1_pa[PWA_W-1 -: PTAG_W];

  always_comb begin
    any_hit  = 1'b0;
    hit_way  = '0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      way_hit[w] = cd_vld[w] && (cd_tag[w] == s1_ptag);
      if (way_hit[w]) begin
        any_hit  = 1'b1;
        hit_way  = hit_way | WAY_W'(w);
        hit_data = hit_data | cd_data[w];
      end
    end
  end

  vipt_plru #(.SETS(SETS), .WAYS(WAYS)) i_plru (
    .clk(clk), .rst_n(rst_n), .upd_en(s1_valid_q && tlb_hit && any_hit),
    .set_sel(s1_va_q[LW +: IDX_W]), .upd_way(hit_way), .victim(victim));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      s1_valid_q <= 1'b0;
      rsp_valid  <= 1'b0;
    end else begin
      s1_valid_q <= rd_en;
      rsp_valid  <= s1_valid_q && tlb_hit;
      case (st_q)
        ST_IDLE:   if (s1_tlbmiss) st_q <= ST_WAIT;
        ST_WAIT:   if (fill_valid) st_q <= ST_REPLAY;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) s1_va_q <= rd_va;
    if (st_q == ST_IDLE && s1_tlbmiss) saved_va_q <= s1_va_q;
    rsp_hit    <= any_hit;
    rsp_way    <= hit_way;
    rsp_data   <= hit_data;
    rsp_paddr  <= s1_pa;
    rsp_victim <= victim;
  end

  assign tlbmiss_req = (st_q == ST_WAIT);
  assign tlbmiss_vpn = saved_va_q[WA_W-1 -: VPN_W];
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk #(
  parameter int WAYS  = 8,
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             tlbmiss_req,
  input logic [VPN_W-1:0] tlbmiss_vpn,
  input logic             fill_valid,
  input logic             s1_valid,
  input logic [WAYS-1:0]  way_hit
);
  // R5
  miss_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlbmiss_req |-> !req_ready);
  // R5
  miss_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbmiss_req && !fill_valid) |=> (tlbmiss_req && $stable(tlbmiss_vpn)));
  // R6
  fill_ends_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbmiss_req && fill_valid) |=> !tlbmiss_req);
  // R2
  single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> $onehot0(way_hit));
  // R9
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(s1_valid));
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(.WAYS(WAYS), .VPN_W(VA_W - PAGE_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .tlbmiss_req(tlbmiss_req), .tlbmiss_vpn(tlbmiss_vpn), .fill_valid(fill_valid),
  .s1_valid(s1_valid_q), .way_hit(way_hit));

// File: tb/test_vipt_l1_lookup.sv
module test_vipt_l1_lookup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [29:0] req_vaddr = '0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_way, rsp_victim;
  logic [31:0] rsp_data;
  logic [29:0] rsp_paddr;
  logic        inst_valid = 1'b0;
  logic [2:0]  inst_way = '0;
  logic [29:0] inst_waddr = '0;
  logic [31:0] inst_data = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        tlbmiss_req;
  logic [19:0] tlbmiss_vpn;

  vipt_l1_lookup i_vipt_l1_lookup (.*);

  typedef struct packed {
    logic hit; logic [2:0] way; logic [31:0] data; logic [29:0] pa; logic cv; logic [2:0] vic;
  } exp_t;
  exp_t  exp_q[$];
  string rq_q[$];
  int errors = 0, checks = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected response", 64'(rsp_paddr), 64'h0);
      end else begin
        exp_t e; string r; bit ok;
        e = exp_q.pop_front(); r = rq_q.pop_front();
        ok = rsp_hit == e.hit && rsp_paddr == e.pa && (!e.cv || rsp_victim == e.vic) &&
             (e.hit ? (rsp_way == e.way && rsp_data == e.data) : rsp_data == 32'h0);
        check(ok, r, "response {hit,way,data,pa,victim}",
              {rsp_hit, rsp_way, rsp_data[15:0], 12'h0, rsp_paddr[15:0], 5'h0, rsp_victim},
              {e.hit, e.way, e.data[15:0], 12'h0, e.pa[15:0], 5'h0, e.vic});
      end
    end
  end

  task automatic issue(input logic [31:0] va, input logic ehit, input logic [2:0] eway,
                       input logic [31:0] edata, input logic [31:0] epa, input logic cv,
                       input logic [2:0] ev, input string rq);
    while (!req_ready) @(negedge clk);
    exp_q.push_back({ehit, eway, edata, epa[31:2], cv, ev});
    rq_q.push_back(rq);
    req_valid = 1'b1; req_vaddr = va[31:2];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic install(input logic [2:0] way, input logic [31:0] pa, input logic [31:0] d);
    inst_valid = 1'b1; inst_way = way; inst_waddr = pa[31:2]; inst_data = d;
    @(negedge clk);
    inst_valid = 1'b0;
  endtask

  task automatic handle_miss(input logic [19:0] evpn, input logic [19:0] ppn, input string rq);
    for (int i = 0; i < 50 && !tlbmiss_req; i++) @(negedge clk);
    check(tlbmiss_req == 1'b1, rq, "tlbmiss_req", 64'(tlbmiss_req), 64'h1);
    check(tlbmiss_vpn == evpn, rq, "tlbmiss_vpn", 64'(tlbmiss_vpn), 64'(evpn));
    check(req_ready == 1'b0 && rsp_valid == 1'b0, "R5", "ready/rsp during miss",
          64'({req_ready, rsp_valid}), 64'h0);
    @(negedge clk);
    check(tlbmiss_req == 1'b1, "R5", "request held", 64'(tlbmiss_req), 64'h1);
    fill(evpn, ppn);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 64'h0, 64'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'h1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'h0);
    check(tlbmiss_req == 1'b0, "R1", "tlbmiss_req", 64'(tlbmiss_req), 64'h0);

    // R1/R5/R6: empty TLB -> miss, fill, replay; line absent -> R3 miss, victim 0
    fork
      issue(32'h0001_0040, 1'b0, 3'd0, 32'h0, 32'h1234_5040, 1'b1, 3'd0, "R6");
      handle_miss(20'h00010, 20'h12345, "R1");
    join
    repeat (4) @(negedge clk);

    // R2 hit in set 1 way 3, word 1
    install(3'd3, 32'h1234_5044, 32'hA5A5_0003);
    issue(32'h0001_0044, 1'b1, 3'd3, 32'hA5A5_0003, 32'h1234_5044, 1'b0, 3'd0, "R2");

    // R8: eight physical lines in set 2, probe page 0x00011
    fill(20'h00011, 20'h2222A);
    for (int k = 0; k < 8; k++)
      install(3'(k), 32'h1234_5080 + 32'(k) * 32'h200, 32'hD000_0000 + 32'(k));
    issue(32'h0001_1080, 1'b0, 3'd0, 32'h0, 32'h2222_A080, 1'b1, 3'd0, "R8");
    issue(32'h0001_0080, 1'b1, 3'd0, 32'hD000_0000, 32'h1234_5080, 1'b0, 3'd0, "R2");
    issue(32'h0001_1080, 1'b0, 3'd0, 32'h0, 32'h2222_A080, 1'b1, 3'd4, "R8");
    issue(32'h0001_0880, 1'b1, 3'd4, 32'hD000_0004, 32'h1234_5880, 1'b0, 3'd0, "R2");
    issue(32'h0001_1080, 1'b0, 3'd0, 32'h0, 32'h2222_A080, 1'b1, 3'd2, "R8");
    // R9 back-to-back hits across all ways
    for (int k = 0; k < 8; k++)
      issue(32'h0001_0080 + 32'(k) * 32'h200, 1'b1, 3'(k), 32'hD000_0000 + 32'(k),
            32'h1234_5080 + 32'(k) * 32'h200, 1'b0, 3'd0, "R9");
    issue(32'h0001_1080, 1'b0, 3'd0, 32'h0, 32'h2222_A080, 1'b1, 3'd0, "R8");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9", "responses drained", 64'(exp_q.size()), 64'h0);

    // R4 synonym: second virtual page onto the same physical page
    fill(20'h00050, 20'h12345);
    issue(32'h0005_0044, 1'b1, 3'd3, 32'hA5A5_0003, 32'h1234_5044, 1'b0, 3'd0, "R4");
    issue(32'h0005_0480, 1'b1, 3'd2, 32'hD000_0002, 32'h1234_5480, 1'b0, 3'd0, "R4");

    // R7 round robin in TLB set 0: slots 0x10,0x50 used; add 0x20,0x30, then 0x40 evicts 0x10
    fill(20'h00020, 20'h33333);
    fill(20'h00030, 20'h44444);
    fill(20'h00040, 20'h12345);
    issue(32'h0004_0044, 1'b1, 3'd3, 32'hA5A5_0003, 32'h1234_5044, 1'b0, 3'd0, "R7");
    repeat (4) @(negedge clk);
    // R10: younger request behind a TLB miss waits and completes after the replay
    fork
      begin
        issue(32'h0001_0044, 1'b1, 3'd3, 32'hA5A5_0003, 32'h1234_5044, 1'b0, 3'd0, "R7");
        issue(32'h0004_0480, 1'b1, 3'd2, 32'hD000_0002, 32'h1234_5480, 1'b0, 3'd0, "R10");
      end
      handle_miss(20'h00010, 20'h12345, "R7");
    join
    repeat (4) @(negedge clk);
    // refill of 0x10 displaced 0x50
    fork
      issue(32'h0005_0044, 1'b1, 3'd3, 32'hA5A5_0003, 32'h1234_5044, 1'b0, 3'd0, "R6");
      handle_miss(20'h00050, 20'h12345, "R7");
    join
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R6", "all responses seen", 64'(exp_q.size()), 64'h0);
    check(req_ready == 1'b1 && tlbmiss_req == 1'b0, "R6", "idle after replay",
          64'({req_ready, tlbmiss_req}), 64'h2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule